// File: doc/BRIEF.md
# Counter-Addressed Serial Latch Bank

This block holds a row of single-bit storage cells that are filled one bit at a time from a single serial data input. The cell to write is picked by an internal address counter, not by address pins. A caller sets the data bit and raises the strobe input, and the selected cell takes the bit. A high-to-low transition on the increment input then moves the counter to the next cell. After the last cell has been written, the full flag pulls low. The flag is modelled as a pull-down enable, so the flags of several banks can share one wired line.

An active-low output enable presents all stored bits in parallel. When that enable is high, the outputs are released. This is modelled as an output-valid signal plus data that is forced to zero. An active-low reset clears the cells, the counter and the flag. The strobe and increment inputs are brought into the system clock domain through a synchroniser chain, and their edges are found from consecutive samples.

The strobe handling is a two-state machine, `WR_IDLE` and `WR_ACTIVE`:
- `GO_WRITE` takes `WR_IDLE` to `WR_ACTIVE` on a synchronised rising edge of strobe.
- `END_WRITE` takes `WR_ACTIVE` back to `WR_IDLE` on a synchronised falling edge of strobe.

The flag is a two-state machine, `FL_OPEN` and `FL_PULL`:
- `MARK_FULL` takes `FL_OPEN` to `FL_PULL` when the strobe falls while the counter holds the last address.
- `FL_PULL` is left only by reset (`CLR_FULL`).

Top module: `serial_latch_bank`

## Requirements
- R1: While rst_n is low, every stored bit reads 0, the counter returns to address 0 and full_pull is 0 (line released).
- R2: Each synchronised falling edge of incr_in advances the counter by one. From address NUM_BITS-1 (7 by default) it wraps to 0. Without a falling edge, the counter holds.
- R3: While the write machine is in WR_ACTIVE (strobe high), the cell at the current address takes data_in. Every other cell keeps its value.
- R4: With oe_n_in low, q_oe is 1 and bit i of q_out equals stored cell i. Cell i is the bit written at counter address i.
- R5: With oe_n_in high, q_oe is 0 and q_out is all zeros.
- R6: A synchronised falling edge of strobe while the counter holds address NUM_BITS-1 sets full_pull to 1. It then stays 1 until reset, even across counter wrap and further writes.
- R7: A falling edge of strobe at any address other than NUM_BITS-1 leaves full_pull at 0.
- R8: Reset takes priority over strobe. A strobe pulse given while rst_n is low writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset, asynchronous assertion |
| data_in | input | 1 | Serial data bit, held stable while strobe is high |
| strobe_in | input | 1 | Write strobe, asynchronous, active high |
| incr_in | input | 1 | Counter step; the falling edge advances the address |
| oe_n_in | input | 1 | Active-low parallel output enable |
| q_out | output | NUM_BITS | Parallel stored bits, zero while released |
| q_oe | output | 1 | High when q_out is driven |
| full_pull | output | 1 | Pull-down enable for the shared open-drain full line |

## Verification
A counter that is off by one, or that fails to wrap, shows up at the ports in two ways. The serially written pattern appears rotated or shifted on q_out as soon as the enable is lowered. The full flag also rises one write early, one write late, or never. A write enable that touches the wrong cell corrupts a single bit, which is visible on the next parallel read. A flag machine that leaves FL_PULL without a reset is caught after any later write at another address. The bench sweeps every 8-bit pattern, so every bit position is checked with both values and next to both neighbour values.

// File: rtl/slb_pkg.sv
package slb_pkg;

    typedef enum logic {
        WR_IDLE   = 1'b0,
        WR_ACTIVE = 1'b1
    } wr_state_t;

    typedef enum logic {
        FL_OPEN = 1'b0,
        FL_PULL = 1'b1
    } fl_state_t;

endpackage

// File: rtl/slb_edge_sync.sv
module slb_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/slb_addr_counter.sv
module slb_addr_counter #(
    parameter int NUM_BITS = 8,
    localparam int ADDR_W  = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_BITS - 1);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (step) begin
            addr_q <= (addr_q == LAST) ? '0 : addr_q + ADDR_W'(1);
        end
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == LAST);
endmodule

// File: rtl/slb_store.sv
module slb_store #(
    parameter int NUM_BITS = 8,
    localparam int ADDR_W  = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                din,
    output logic [NUM_BITS-1:0] bits
);
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
        logic cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= 1'b0;
            end else if (wr_en && (addr == ADDR_W'(i))) begin
                cell_q <= din;
            end
        end
        assign bits[i] = cell_q;
    end
endmodule

// File: rtl/serial_latch_bank.sv
module serial_latch_bank
    import slb_pkg::*;
#(
    parameter int NUM_BITS    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_in,
    input  logic                strobe_in,
    input  logic                incr_in,
    input  logic                oe_n_in,
    output logic [NUM_BITS-1:0] q_out,
    output logic                q_oe,
    output logic                full_pull
);
    logic              stb_level, stb_rise, stb_fall;
    logic              inc_level, inc_rise, inc_fall;
    logic [ADDR_W-1:0] addr_q;
    logic              at_last;
    logic              wr_en;
    logic [NUM_BITS-1:0] store_q;

    wr_state_t wr_state, wr_next;
    fl_state_t fl_state, fl_next;

    slb_edge_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .din(strobe_in),
        .level(stb_level), .rise(stb_rise), .fall(stb_fall)
    );

    slb_edge_sync #(.STAGES(SYNC_STAGES)) u_inc_sync (
        .clk(clk), .rst_n(rst_n), .din(incr_in),
        .level(inc_level), .rise(inc_rise), .fall(inc_fall)
    );

    slb_addr_counter #(.NUM_BITS(NUM_BITS)) u_counter (
        .clk(clk), .rst_n(rst_n), .step(inc_fall),
        .addr(addr_q), .at_last(at_last)
    );

    slb_store #(.NUM_BITS(NUM_BITS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr_q), .din(data_in), .bits(store_q)
    );

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_state <= WR_IDLE;
            fl_state <= FL_OPEN;
        end else begin
            wr_state <= wr_next;
            fl_state <= fl_next;
        end
    end

    // transitions
    always_comb begin
        wr_next = wr_state;
        fl_next = fl_state;
        unique case (wr_state)
            WR_IDLE:   if (stb_rise) wr_next = WR_ACTIVE;   // GO_WRITE
            WR_ACTIVE: if (stb_fall) wr_next = WR_IDLE;     // END_WRITE
            default:   wr_next = WR_IDLE;
        endcase
        unique case (fl_state)
            FL_OPEN: if (stb_fall && at_last) fl_next = FL_PULL; // MARK_FULL
            FL_PULL: fl_next = FL_PULL;                          // left by reset only
            default: fl_next = FL_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        wr_en     = (wr_state == WR_ACTIVE) && stb_level;
        full_pull = (fl_state == FL_PULL);
        q_oe      = ~oe_n_in;
        q_out     = oe_n_in ? '0 : store_q;
    end

    logic unused_inc;
    assign unused_inc = inc_level ^ inc_rise;
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
    parameter int NUM_BITS = 8,
    localparam int ADDR_W  = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                data_in,
    input logic                oe_n_in,
    input logic [NUM_BITS-1:0] q_out,
    input logic                q_oe,
    input logic                full_pull,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic                stb_fall,
    input logic                inc_fall,
    input logic [NUM_BITS-1:0] bits
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_BITS - 1);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (bits == '0 && addr == '0 && !full_pull);
            p_reset_blocks_r8: assert (!wr_en);
        end
    end

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc_fall |=> addr == (($past(addr) == LAST) ? '0 : $past(addr) + ADDR_W'(1)));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_fall |=> $stable(addr));

    p_write_cell_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bits[$past(addr)] == $past(data_in));

    p_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bits));

    p_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_in |-> (q_oe && q_out == bits));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_in |-> (!q_oe && q_out == '0));

    p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_pull |=> full_pull);

    p_full_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_pull) |-> $past(stb_fall && addr == LAST));
endmodule

bind serial_latch_bank slb_checker #(.NUM_BITS(NUM_BITS)) u_slb_checker (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .oe_n_in(oe_n_in),
    .q_out(q_out), .q_oe(q_oe), .full_pull(full_pull),
    .addr(addr_q), .wr_en(wr_en), .stb_fall(stb_fall),
    .inc_fall(inc_fall), .bits(store_q)
);

// File: tb/test_serial_latch_bank.sv
module test_serial_latch_bank;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         data_in = 1'b0;
    logic         strobe_in = 1'b0;
    logic         incr_in = 1'b0;
    logic         oe_n_in = 1'b1;
    logic [N-1:0] q_out;
    logic         q_oe;
    logic         full_pull;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_latch_bank #(.NUM_BITS(N)) i_serial_latch_bank (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .strobe_in(strobe_in),
        .incr_in(incr_in), .oe_n_in(oe_n_in), .q_out(q_out), .q_oe(q_oe),
        .full_pull(full_pull)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic strobe_bit(input logic b);
        data_in = b;
        strobe_in = 1'b1;
        wait_cyc(5);
        strobe_in = 1'b0;
        wait_cyc(5);
    endtask

    task automatic step_addr();
        incr_in = 1'b1;
        wait_cyc(5);
        incr_in = 1'b0;
        wait_cyc(5);
    endtask

    task automatic read_par(output logic [N-1:0] v, output logic oe);
        oe_n_in = 1'b0;
        wait_cyc(1);
        v = q_out;
        oe = q_oe;
        oe_n_in = 1'b1;
        wait_cyc(1);
    endtask

    initial begin
        logic [N-1:0] v;
        logic         oe;

        // R1 reset state
        wait_cyc(3);
        read_par(v, oe);
        check("R1 bits after reset", {24'd0, v}, 32'd0);
        check("R1 flag after reset", {31'd0, full_pull}, 32'd0);
        rst_n = 1'b1;
        wait_cyc(2);

        // sweep every pattern
        for (int p = 0; p < (1 << N); p++) begin
            logic [N-1:0] pat;
            pat = N'(p);
            do_reset();
            for (int i = 0; i < N; i++) begin
                strobe_bit(pat[i]);
                if (i == N - 2) check("R7 no flag before last", {31'd0, full_pull}, 32'd0);
                if (i == N - 1) check("R6 flag on last write", {31'd0, full_pull}, 32'd1);
                step_addr();
            end
            read_par(v, oe);
            check("R4 parallel pattern", {24'd0, v}, {24'd0, pat});
            check("R4 output valid", {31'd0, oe}, 32'd1);
            check("R5 released data", {24'd0, q_out}, 32'd0);
            check("R5 released valid", {31'd0, q_oe}, 32'd0);
            if (p % 37 == 5) begin
                // R2 wrap: counter back at 0, overwrite cell 0 only
                strobe_bit(~pat[0]);
                read_par(v, oe);
                check("R2 wrap writes cell 0", {24'd0, v}, {24'd0, pat ^ N'(1)});
                check("R6 flag sticky", {31'd0, full_pull}, 32'd1);
                // R3: a step then write touches only cell 1
                step_addr();
                strobe_bit(~pat[1]);
                read_par(v, oe);
                check("R3 single cell write", {24'd0, v}, {24'd0, pat ^ N'(3)});
            end
        end

        // R7: strobe at address 3 only, no flag
        do_reset();
        step_addr(); step_addr(); step_addr();
        strobe_bit(1'b1);
        check("R7 mid address no flag", {31'd0, full_pull}, 32'd0);
        read_par(v, oe);
        check("R2 three steps reach cell 3", {24'd0, v}, 32'h08);

        // R8: strobe while held in reset
        @(negedge clk);
        rst_n = 1'b0;
        strobe_bit(1'b1);
        check("R1 flag released in reset", {31'd0, full_pull}, 32'd0);
        rst_n = 1'b1;
        wait_cyc(3);
        read_par(v, oe);
        check("R8 no write during reset", {24'd0, v}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule